// File: doc/BRIEF.md
# Receive Descriptor Ring Write-Back Engine

This block keeps the receive side of a packet DMA in step with software through a ring of two-word buffer descriptors held in a small local memory. Software fills each descriptor with a buffer address, marks the last one with a wrap flag, and hands it to the engine by leaving the used flag clear. The DMA reports each filled buffer as a one-cycle completion event carrying a length and start-of-frame and end-of-frame markers. On that event the engine checks that the current descriptor is free. It then writes the length and markers into the descriptor, sets its used flag, and moves to the next descriptor. After a descriptor with the wrap flag it jumps back to the ring base. The address of the buffer to fill next is always shown on an output.

If a buffer completes while the current descriptor is still owned by software, the data is discarded and the pointer stays where it is. A sticky buffer-not-available flag is raised, and software clears it by writing a one. Software reaches the descriptor memory and three registers through one flat word-addressed port. The registers are control (bit 2 enables reception), ring base (a descriptor index) and status (bit 0 is the sticky flag).

Top module: `rxring_wb`

## Requirements
- R1: After reset, ringPtr is 0, wbPulse and bnaFlag are 0, and the control, base and status registers read 0.
- R2: While reception is disabled (control bit 2 = 0), a completion event writes no descriptor, leaves ringPtr unchanged, gives no wbPulse and does not set bnaFlag.
- R3: While enabled, a completion event on a descriptor whose word 0 bit 0 (used) is 0 sets that bit and keeps the other word 0 bits. It writes word 1 as length in bits 13:0, start-of-frame in bit 14, end-of-frame in bit 15, and zeros above. wbPulse is high in the following cycle.
- R4: After an accepted event on a descriptor whose word 0 bit 1 (wrap) is 0, ringPtr is the next index in the following cycle. bufAddr then shows that descriptor's word 0 with bits 1:0 forced to 0.
- R5: After an accepted event on a descriptor with the wrap bit set, ringPtr equals the ring base register in the following cycle.
- R6: While enabled, an event on a descriptor whose used bit is 1 changes no descriptor and leaves ringPtr unchanged. It sets bnaFlag, which stays set until software writes 1 to status bit 0.
- R7: Writing the base register while reception is disabled loads ringPtr with the written index. Writing it while enabled leaves ringPtr unchanged.
- R8: Completion events in consecutive cycles are each written back to successive descriptors.
- R9: Past the last memory index (DEPTH-1) with no wrap bit set, ringPtr rolls over to index 0.
- R10: Port map: address bit 5 = 0 selects descriptor memory, with index in bits 4:1 and word in bit 0. Address 0x20 is control (only bit 2 is stored and read back), 0x21 is base and 0x22 is status. Descriptors read back exactly what software wrote.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rxBufDone | input | 1 | One buffer filled (one cycle per buffer) |
| rxBufLen | input | 14 | Bytes stored in that buffer |
| rxBufSof | input | 1 | Buffer starts a frame |
| rxBufEof | input | 1 | Buffer ends a frame |
| cfgWe | input | 1 | Software write strobe |
| cfgAddr | input | 6 | Software word address |
| cfgWdata | input | 32 | Software write data |
| cfgRdata | output | 32 | Software read data (combinational from cfgAddr) |
| wbPulse | output | 1 | A descriptor was written back at the last edge |
| bnaFlag | output | 1 | Sticky buffer-not-available |
| ringPtr | output | 4 | Index of the current descriptor |
| bufAddr | output | 32 | Buffer address of the current descriptor |

## Verification
The bench applies an event or a register write for exactly one clock edge. Every result (descriptor contents, ringPtr, bufAddr, wbPulse and bnaFlag) is due in the cycle right after that edge, because a single register stage sits between the inputs and each result. The bench samples on the falling edge that follows the active edge and reads the descriptor memory back through the combinational read port in that same half cycle. In the back-to-back case it checks the first result on the falling edge that separates the two events.

// File: rtl/rxring_pkg.sv
package rxring_pkg;
  localparam int LEN_W       = 14;
  localparam int USED_BIT    = 0;
  localparam int WRAP_BIT    = 1;
  localparam int SOF_BIT     = 14;
  localparam int EOF_BIT     = 15;
  localparam int CTRL_EN_BIT = 2;

  localparam logic [1:0] REG_CTRL = 2'd0;
  localparam logic [1:0] REG_BASE = 2'd1;
  localparam logic [1:0] REG_STAT = 2'd2;

  typedef struct packed {
    logic wbEn;      // write back the current descriptor
    logic advance;   // step to the next index
    logic wrapJump;  // return to ring base
    logic setBna;    // raise buffer-not-available
  } rxStrobe_t;
endpackage

// File: rtl/rxring_ctrl.sv
module rxring_ctrl
  import rxring_pkg::*;
(
  input  logic      rxEn,
  input  logic      bufDone,
  input  logic      curUsed,
  input  logic      curWrap,
  output rxStrobe_t strb
);
  logic accept;
  logic refuse;

  always_comb begin
    accept        = rxEn && bufDone && !curUsed;
    refuse        = rxEn && bufDone && curUsed;
    strb.wbEn     = accept;
    strb.advance  = accept && !curWrap;
    strb.wrapJump = accept && curWrap;
    strb.setBna   = refuse;
  end
endmodule

// File: rtl/rxring_dp.sv
module rxring_dp
  import rxring_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int IDX_W  = $clog2(DEPTH),
  parameter int ADDR_W = IDX_W + 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  rxStrobe_t         strb,
  input  logic [LEN_W-1:0]  bufLen,
  input  logic              bufSof,
  input  logic              bufEof,
  input  logic              cfgWe,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic [31:0]       cfgWdata,
  output logic [31:0]       cfgRdata,
  output logic              rxEn,
  output logic              curUsed,
  output logic              curWrap,
  output logic              wbPulse,
  output logic              bnaFlag,
  output logic [IDX_W-1:0]  ringPtr,
  output logic [31:0]       bufAddr
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);

  logic [31:0]      word0Arr [DEPTH];
  logic [31:0]      word1Arr [DEPTH];
  logic [IDX_W-1:0] baseIdx;
  logic             regHit;
  logic             descHit;
  logic [IDX_W-1:0] descIdx;
  logic             descWord;
  logic [1:0]       regSel;
  logic             baseWr;
  logic             ctrlWr;
  logic             statClr;
  logic [31:0]      statusWord;
  logic [31:0]      curWord0;

  always_comb begin
    descHit  = !cfgAddr[ADDR_W-1];
    regHit   = cfgAddr[ADDR_W-1] && (cfgAddr[ADDR_W-2:2] == '0);
    descIdx  = cfgAddr[ADDR_W-2:1];
    descWord = cfgAddr[0];
    regSel   = cfgAddr[1:0];
    baseWr   = cfgWe && regHit && (regSel == REG_BASE);
    ctrlWr   = cfgWe && regHit && (regSel == REG_CTRL);
    statClr  = cfgWe && regHit && (regSel == REG_STAT) && cfgWdata[0];
    statusWord = '0;
    statusWord[LEN_W-1:0] = bufLen;
    statusWord[SOF_BIT]   = bufSof;
    statusWord[EOF_BIT]   = bufEof;
  end

  for (genvar i = 0; i < DEPTH; i++) begin : gEntry
    logic [31:0] w0;
    logic [31:0] w1;
    logic        hitWb;
    logic        hitSw;
    assign hitWb = strb.wbEn && (ringPtr == IDX_W'(i));
    assign hitSw = cfgWe && descHit && (descIdx == IDX_W'(i));
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        w0 <= '0;
        w1 <= '0;
      end else if (hitWb) begin
        w0[USED_BIT] <= 1'b1;
        w1           <= statusWord;
      end else if (hitSw) begin
        if (descWord) w1 <= cfgWdata;
        else          w0 <= cfgWdata;
      end
    end
    assign word0Arr[i] = w0;
    assign word1Arr[i] = w1;
  end

  always_comb begin
    curWord0 = word0Arr[ringPtr];
    curUsed  = curWord0[USED_BIT];
    curWrap  = curWord0[WRAP_BIT];
    bufAddr  = {curWord0[31:2], 2'b00};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ringPtr <= '0;
      baseIdx <= '0;
      rxEn    <= 1'b0;
      bnaFlag <= 1'b0;
      wbPulse <= 1'b0;
    end else begin
      wbPulse <= strb.wbEn;
      if (ctrlWr) rxEn <= cfgWdata[CTRL_EN_BIT];
      if (baseWr) baseIdx <= cfgWdata[IDX_W-1:0];
      if (strb.setBna)  bnaFlag <= 1'b1;
      else if (statClr) bnaFlag <= 1'b0;
      if (strb.wrapJump)
        ringPtr <= baseIdx;
      else if (strb.advance)
        ringPtr <= (ringPtr == LAST_IDX) ? '0 : ringPtr + 1'b1;
      else if (baseWr && !rxEn)
        ringPtr <= cfgWdata[IDX_W-1:0];
    end
  end

  always_comb begin
    cfgRdata = '0;
    if (descHit) begin
      cfgRdata = descWord ? word1Arr[descIdx] : word0Arr[descIdx];
    end else if (regHit) begin
      case (regSel)
        REG_CTRL: cfgRdata[CTRL_EN_BIT] = rxEn;
        REG_BASE: cfgRdata[IDX_W-1:0]   = baseIdx;
        REG_STAT: cfgRdata[0]           = bnaFlag;
        default:  cfgRdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/rxring_wb.sv
module rxring_wb
  import rxring_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int IDX_W  = $clog2(DEPTH),
  parameter int ADDR_W = IDX_W + 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxBufDone,
  input  logic [LEN_W-1:0]  rxBufLen,
  input  logic              rxBufSof,
  input  logic              rxBufEof,
  input  logic              cfgWe,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic [31:0]       cfgWdata,
  output logic [31:0]       cfgRdata,
  output logic              wbPulse,
  output logic              bnaFlag,
  output logic [IDX_W-1:0]  ringPtr,
  output logic [31:0]       bufAddr
);
  rxStrobe_t strb;
  logic      rxEn;
  logic      curUsed;
  logic      curWrap;

  rxring_ctrl uCtrl (
    .rxEn    (rxEn),
    .bufDone (rxBufDone),
    .curUsed (curUsed),
    .curWrap (curWrap),
    .strb    (strb)
  );

  rxring_dp #(.DEPTH(DEPTH), .IDX_W(IDX_W), .ADDR_W(ADDR_W)) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .bufLen   (rxBufLen),
    .bufSof   (rxBufSof),
    .bufEof   (rxBufEof),
    .cfgWe    (cfgWe),
    .cfgAddr  (cfgAddr),
    .cfgWdata (cfgWdata),
    .cfgRdata (cfgRdata),
    .rxEn     (rxEn),
    .curUsed  (curUsed),
    .curWrap  (curWrap),
    .wbPulse  (wbPulse),
    .bnaFlag  (bnaFlag),
    .ringPtr  (ringPtr),
    .bufAddr  (bufAddr)
  );
endmodule

// File: rtl/rxring_chk.sv
module rxring_chk #(
  parameter int IDX_W  = 4,
  parameter int ADDR_W = IDX_W + 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              rxBufDone,
  input logic              cfgWe,
  input logic [ADDR_W-1:0] cfgAddr,
  input logic [31:0]       cfgWdata,
  input logic              rxEn,
  input logic              curUsed,
  input logic              wbPulse,
  input logic              bnaFlag,
  input logic [IDX_W-1:0]  ringPtr
);
  localparam logic [ADDR_W-1:0] BASE_ADDR = {1'b1, {(ADDR_W-3){1'b0}}, 2'd1};
  localparam logic [ADDR_W-1:0] STAT_ADDR = {1'b1, {(ADDR_W-3){1'b0}}, 2'd2};

  logic baseLd;
  logic bnaClr;
  assign baseLd = cfgWe && (cfgAddr == BASE_ADDR);
  assign bnaClr = cfgWe && (cfgAddr == STAT_ADDR) && cfgWdata[0];

  // R2
  a_r2_ignore_when_off: assert property (@(posedge clk) disable iff (!rstN)
    (rxBufDone && !rxEn) |=> !wbPulse);

  // R3
  a_r3_pulse_follows_event: assert property (@(posedge clk) disable iff (!rstN)
    wbPulse |-> $past(rxBufDone));

  // R6
  a_r6_bna_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (bnaFlag && !bnaClr) |=> bnaFlag);

  // R6
  a_r6_refuse_holds_ptr: assert property (@(posedge clk) disable iff (!rstN)
    (rxBufDone && rxEn && curUsed) |=> ($stable(ringPtr) && !wbPulse && bnaFlag));

  // R7
  a_r7_ptr_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (!rxBufDone && !(baseLd && !rxEn)) |=> $stable(ringPtr));
endmodule

bind rxring_wb rxring_chk #(.IDX_W(IDX_W), .ADDR_W(ADDR_W)) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .rxBufDone (rxBufDone),
  .cfgWe     (cfgWe),
  .cfgAddr   (cfgAddr),
  .cfgWdata  (cfgWdata),
  .rxEn      (rxEn),
  .curUsed   (curUsed),
  .wbPulse   (wbPulse),
  .bnaFlag   (bnaFlag),
  .ringPtr   (ringPtr)
);

// File: tb/sim_rxring_wb.sv
`timescale 1ns/1ps
module sim_rxring_wb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        rxBufDone = 1'b0;
  logic [13:0] rxBufLen = '0;
  logic        rxBufSof = 1'b0;
  logic        rxBufEof = 1'b0;
  logic        cfgWe = 1'b0;
  logic [5:0]  cfgAddr = '0;
  logic [31:0] cfgWdata = '0;
  logic [31:0] cfgRdata;
  logic        wbPulse;
  logic        bnaFlag;
  logic [3:0]  ringPtr;
  logic [31:0] bufAddr;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  rxring_wb u0 (.*);

  typedef struct packed {
    logic [13:0] len;
    logic        sof;
    logic        eof;
    logic        acc;
    logic [3:0]  ptr;
  } vec_t;

  localparam vec_t VECS [5] = '{
    '{len: 14'd100,  sof: 1'b1, eof: 1'b0, acc: 1'b1, ptr: 4'd1},
    '{len: 14'd200,  sof: 1'b0, eof: 1'b0, acc: 1'b1, ptr: 4'd2},
    '{len: 14'd300,  sof: 1'b0, eof: 1'b1, acc: 1'b1, ptr: 4'd3},
    '{len: 14'd64,   sof: 1'b1, eof: 1'b1, acc: 1'b1, ptr: 4'd0},
    '{len: 14'd1500, sof: 1'b1, eof: 1'b1, acc: 1'b0, ptr: 4'd0}
  };

  function automatic logic [5:0] dA(input logic [3:0] idx, input logic w);
    return {1'b0, idx, w};
  endfunction
  localparam logic [5:0] A_CTRL = 6'h20;
  localparam logic [5:0] A_BASE = 6'h21;
  localparam logic [5:0] A_STAT = 6'h22;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic swWrite(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    cfgWe = 1'b1; cfgAddr = a; cfgWdata = d;
    @(posedge clk);
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic swRead(input logic [5:0] a, output logic [31:0] d);
    cfgAddr = a;
    #0.5;
    d = cfgRdata;
  endtask

  task automatic pushBuf(input logic [13:0] len, input logic sof, input logic eof);
    @(negedge clk);
    rxBufDone = 1'b1; rxBufLen = len; rxBufSof = sof; rxBufEof = eof;
    @(posedge clk);
    @(negedge clk);
    rxBufDone = 1'b0;
  endtask

  function automatic logic [31:0] stWord(input logic [13:0] len, input logic sof, input logic eof);
    return {16'h0, eof, sof, len};
  endfunction

  task automatic summary;
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    #400000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    logic [3:0]  cur;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 ringPtr", 32'(ringPtr), 0);
    chk("R1 wbPulse", 32'(wbPulse), 0);
    chk("R1 bnaFlag", 32'(bnaFlag), 0);
    swRead(A_CTRL, rd); chk("R1 ctrl", rd, 0);
    swRead(A_BASE, rd); chk("R1 base", rd, 0);
    swRead(A_STAT, rd); chk("R1 status", rd, 0);

    // build a ring of four, wrap at index 3
    for (int i = 0; i < 4; i++) begin
      swWrite(dA(4'(i), 1'b0), 32'h1000 * (i + 1) | ((i == 3) ? 32'h2 : 32'h0));
      swWrite(dA(4'(i), 1'b1), 32'h0);
    end
    swRead(dA(4'd3, 1'b0), rd); chk("R10 desc readback", rd, 32'h4002);
    chk("R4 bufAddr initial", bufAddr, 32'h1000);

    // R2 disabled: event ignored
    pushBuf(14'd77, 1'b1, 1'b1);
    chk("R2 wbPulse", 32'(wbPulse), 0);
    chk("R2 ringPtr", 32'(ringPtr), 0);
    chk("R2 bnaFlag", 32'(bnaFlag), 0);
    swRead(dA(4'd0, 1'b0), rd); chk("R2 word0", rd, 32'h1000);
    swRead(dA(4'd0, 1'b1), rd); chk("R2 word1", rd, 32'h0);

    // enable, R10 only bit 2 stored
    swWrite(A_CTRL, 32'hFFFF_FFFF);
    swRead(A_CTRL, rd); chk("R10 ctrl", rd, 32'h4);

    // vector table: R3 R4 R5 R6
    cur = 4'd0;
    for (int v = 0; v < 5; v++) begin
      pushBuf(VECS[v].len, VECS[v].sof, VECS[v].eof);
      chk($sformatf("R3 wbPulse vec%0d", v), 32'(wbPulse), 32'(VECS[v].acc));
      chk($sformatf("R4 R5 ringPtr vec%0d", v), 32'(ringPtr), 32'(VECS[v].ptr));
      if (VECS[v].acc) begin
        swRead(dA(cur, 1'b1), rd);
        chk($sformatf("R3 word1 vec%0d", v), rd, stWord(VECS[v].len, VECS[v].sof, VECS[v].eof));
        swRead(dA(cur, 1'b0), rd);
        chk($sformatf("R3 word0 vec%0d", v), rd,
            32'h1000 * (32'(cur) + 1) | 32'h1 | ((cur == 4'd3) ? 32'h2 : 32'h0));
        chk($sformatf("R6 no bna vec%0d", v), 32'(bnaFlag), 0);
      end else begin
        swRead(dA(cur, 1'b1), rd);
        chk("R6 refused word1 kept", rd, stWord(14'd100, 1'b1, 1'b0));
        chk("R6 bna set", 32'(bnaFlag), 1);
      end
      cur = VECS[v].ptr;
    end
    chk("R4 bufAddr after wrap", bufAddr, 32'h1000);

    // R6 sticky, then cleared, then recovery after hand-back
    pushBuf(14'd5, 1'b0, 1'b0);
    chk("R6 bna still set", 32'(bnaFlag), 1);
    chk("R6 ptr held", 32'(ringPtr), 0);
    swRead(A_STAT, rd); chk("R6 status reg", rd, 1);
    swWrite(A_STAT, 32'h1);
    chk("R6 bna cleared", 32'(bnaFlag), 0);
    swWrite(dA(4'd0, 1'b0), 32'h1000);
    pushBuf(14'd42, 1'b1, 1'b1);
    chk("R6 accepted after hand-back", 32'(wbPulse), 1);
    chk("R6 ptr after hand-back", 32'(ringPtr), 1);
    chk("R4 bufAddr desc1", bufAddr, 32'h2000);

    // R7 base write while enabled: pointer stays
    swWrite(A_BASE, 32'd2);
    chk("R7 enabled base write ptr", 32'(ringPtr), 1);
    swWrite(A_CTRL, 32'h0);
    swWrite(A_BASE, 32'd14);
    chk("R7 disabled base write ptr", 32'(ringPtr), 14);
    swRead(A_BASE, rd); chk("R7 base reg", rd, 14);

    // R9 roll past last index, R8 back-to-back events
    swWrite(dA(4'd14, 1'b0), 32'hE000);
    swWrite(dA(4'd15, 1'b0), 32'hF000);
    swWrite(A_CTRL, 32'h4);
    @(negedge clk);
    rxBufDone = 1'b1; rxBufLen = 14'd10; rxBufSof = 1'b1; rxBufEof = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk("R8 first ptr", 32'(ringPtr), 15);
    chk("R8 first pulse", 32'(wbPulse), 1);
    rxBufLen = 14'd11; rxBufSof = 1'b0; rxBufEof = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rxBufDone = 1'b0;
    chk("R9 rollover ptr", 32'(ringPtr), 0);
    chk("R8 second pulse", 32'(wbPulse), 1);
    swRead(dA(4'd14, 1'b1), rd); chk("R8 desc14 word1", rd, stWord(14'd10, 1'b1, 1'b0));
    swRead(dA(4'd15, 1'b1), rd); chk("R8 desc15 word1", rd, stWord(14'd11, 1'b0, 1'b1));
    swRead(dA(4'd14, 1'b0), rd); chk("R3 desc14 word0", rd, 32'hE001);
    @(negedge clk);
    chk("R3 pulse drops", 32'(wbPulse), 0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule